// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block is the converter-side end of a stereo serial audio link, working as a clock slave. An outside source drives the bit clock and the frame clock. The block turns the incoming playback stream into a left and a right word of 24 bits each, and it shifts a pair of 24-bit capture words onto the outgoing data line. Everything runs on a fast system clock. The block samples both serial clocks on that system clock and finds their edges there, so the bit and frame clocks must be synchronous to it and slower than it.

A 3-bit format code picks one of five framings. In some framings the two directions use different justifications. Capture is always 24-bit and is either MSB-justified or in the delayed-MSB style (I2S). Playback can be MSB-justified, I2S, or LSB-justified with 16, 20 or 24 bits. The format code is taken only while the port is held in reset. A frame in progress therefore never sees a format change.

Top module: `audio_serial_port`

## Requirements
- R1: After reset, `sdto`, `rx_valid`, `rx_left` and `rx_right` are 0, and `sdto` stays 0 until the first change of `lrck` seen at a falling edge of `bck`.
- R2: Format codes are 000 = LSB-justified 16-bit playback, 001 = LSB-justified 20-bit playback, 010 = MSB-justified playback, 011 = I2S both directions, 100 = LSB-justified 24-bit playback. Codes 101 to 111 act as 010. The code is captured only while reset is active, and later changes of `mode_sel` have no effect.
- R3: In code 010, the 24 playback bits are the first 24 bits sampled after an `lrck` edge, MSB first. The half-frame with `lrck` high is the left channel.
- R4: In code 011, the playback MSB is the second bit sampled after an `lrck` edge, and the half-frame with `lrck` low is the left channel.
- R5: In the LSB-justified codes, the last N bits sampled before the closing `lrck` edge form the word, with its LSB last. The word is sign-extended from bit N-1 to 24 bits, and earlier bits in the half-frame are ignored.
- R6: `rx_valid` pulses for one system clock after a right half-frame closes, provided a left half-frame came before it. `rx_left` and `rx_right` change only together with that pulse.
- R7: In every code except 011, the capture MSB is driven at the falling `bck` edge where `lrck` changes. One further bit follows at each falling edge, and after 24 bits the line drives 0. The left word goes out while `lrck` is high.
- R8: In code 011, `sdto` is 0 for the first bit period after the `lrck` edge, then carries the 24 capture bits MSB first. The left word goes out while `lrck` is low.
- R9: If a half-frame is shorter than the capture word, only its upper bits are sent (16 bits at 32 bit clocks per frame).
- R10: Each capture word is taken from `cap_left` or `cap_right` at the `lrck` edge that opens its half-frame. Later changes wait for the next half-frame of that channel.
- R11: Playback bits are sampled on rising `bck`, and `sdto` changes only at falling `bck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than and synchronous to `bck` |
| rst_n | input | 1 | Asynchronous active-low reset; format code is captured while low |
| mode_sel | input | 3 | Framing format code |
| bck | input | 1 | Serial bit clock |
| lrck | input | 1 | Frame (channel) clock |
| sdti | input | 1 | Playback serial data in |
| cap_left | input | 24 | Left capture word to transmit |
| cap_right | input | 24 | Right capture word to transmit |
| sdto | output | 1 | Capture serial data out |
| rx_left | output | 24 | Received left word, sign-extended |
| rx_right | output | 24 | Received right word, sign-extended |
| rx_valid | output | 1 | One-clock strobe for a new left/right pair |

## Verification
The assertions take for granted that `bck` stays at each level for at least two system clocks. They also take for granted that `lrck` and `sdti` change only together with a falling `bck`. From that, a pulse on `rx_valid` and any movement on `sdto` can be tied to one exact system clock after a rising or falling bit-clock edge. The stimulus builds each bit period from two low and two high system clocks, and it changes frame clock, data and format code only at the start of a period. It covers 32, 40, 48, 56 and 64 bit clocks per frame, every valid code and one invalid code. It also changes the format code and the capture words in the middle of a run.

// File: rtl/aport_pkg.sv
package aport_pkg;

  typedef enum logic [2:0] {
    FMT_L16 = 3'b000,
    FMT_L20 = 3'b001,
    FMT_MSB = 3'b010,
    FMT_I2S = 3'b011,
    FMT_L24 = 3'b100
  } fmt_e;

  // Unknown codes fall back to the MSB-justified default.
  function automatic fmt_e fmt_decode(input logic [2:0] code);
    fmt_e f;
    case (code)
      3'b000:  f = FMT_L16;
      3'b001:  f = FMT_L20;
      3'b011:  f = FMT_I2S;
      3'b100:  f = FMT_L24;
      default: f = FMT_MSB;
    endcase
    return f;
  endfunction

  // Width of an LSB-justified playback word, 0 when playback is MSB-aligned.
  function automatic int fmt_lsb_bits(input fmt_e f, input int word_w);
    int n;
    case (f)
      FMT_L16: n = 16;
      FMT_L20: n = 20;
      FMT_L24: n = word_w;
      default: n = 0;
    endcase
    return n;
  endfunction

  // Frame clock level that marks the left half-frame.
  function automatic logic fmt_left_level(input fmt_e f);
    return (f == FMT_I2S) ? 1'b0 : 1'b1;
  endfunction

  // Bit slots between the frame edge and the MSB.
  function automatic int fmt_lead(input fmt_e f);
    return (f == FMT_I2S) ? 1 : 0;
  endfunction

endpackage

// File: rtl/aport_edges.sv
module aport_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic bck,
  output logic bck_rise,
  output logic bck_fall
);

  logic bck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bck_q <= 1'b0;
    else        bck_q <= bck;
  end

  assign bck_rise = bck & ~bck_q;
  assign bck_fall = ~bck & bck_q;

endmodule

// File: rtl/aport_rx.sv
module aport_rx
  import aport_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              lr_in,
  input  logic              sd_in,
  input  fmt_e              fmt,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);

  localparam int IDX_W = $clog2(WORD_W);

  logic              seen_q, seen_d;
  logic              synced_q, synced_d;
  logic              lr_q, lr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              hold_ok_q, hold_ok_d;
  logic [WORD_W-1:0] left_q, left_d;
  logic [WORD_W-1:0] right_q, right_d;
  logic              valid_q, valid_d;

  logic              start;
  logic [CNT_W-1:0]  slot;
  logic              take;
  int                lsbn;
  int                lead;
  logic [IDX_W-1:0]  sign_idx;
  logic [WORD_W-1:0] word;

  always_comb begin
    lsbn     = fmt_lsb_bits(fmt, WORD_W);
    lead     = fmt_lead(fmt);
    sign_idx = (lsbn == 0) ? IDX_W'(WORD_W - 1) : IDX_W'(lsbn - 1);
    start    = seen_q && (lr_in != lr_q);
    slot     = start ? '0 : cnt_q;
    take     = (lsbn != 0) ||
               ((int'(slot) >= lead) && (int'(slot) < lead + WORD_W));
    for (int i = 0; i < WORD_W; i++) begin
      word[i] = (i <= int'(sign_idx)) ? sh_q[i] : sh_q[sign_idx];
    end
  end

  always_comb begin
    seen_d    = seen_q;
    synced_d  = synced_q;
    lr_d      = lr_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    hold_d    = hold_q;
    hold_ok_d = hold_ok_q;
    left_d    = left_q;
    right_d   = right_q;
    valid_d   = 1'b0;
    if (rise) begin
      lr_d = lr_in;
      if (!seen_q) begin
        seen_d = 1'b1;
      end else if (start) begin
        if (synced_q) begin
          if (lr_q == fmt_left_level(fmt)) begin
            hold_d    = word;
            hold_ok_d = 1'b1;
          end else if (hold_ok_q) begin
            left_d    = hold_q;
            right_d   = word;
            valid_d   = 1'b1;
            hold_ok_d = 1'b0;
          end
        end
        synced_d = 1'b1;
        cnt_d    = CNT_W'(1);
        sh_d     = take ? {{(WORD_W-1){1'b0}}, sd_in} : '0;
      end else begin
        cnt_d = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
        if (take) sh_d = {sh_q[WORD_W-2:0], sd_in};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      synced_q  <= 1'b0;
      lr_q      <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      hold_q    <= '0;
      hold_ok_q <= 1'b0;
      left_q    <= '0;
      right_q   <= '0;
      valid_q   <= 1'b0;
    end else begin
      seen_q    <= seen_d;
      synced_q  <= synced_d;
      lr_q      <= lr_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      hold_q    <= hold_d;
      hold_ok_q <= hold_ok_d;
      left_q    <= left_d;
      right_q   <= right_d;
      valid_q   <= valid_d;
    end
  end

  assign rx_left  = left_q;
  assign rx_right = right_q;
  assign rx_valid = valid_q;

endmodule

// File: rtl/aport_tx.sv
module aport_tx
  import aport_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              lr_in,
  input  fmt_e              fmt,
  input  logic [WORD_W-1:0] cap_left,
  input  logic [WORD_W-1:0] cap_right,
  output logic              sdto
);

  logic              seen_q, seen_d;
  logic              lr_q, lr_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sd_q, sd_d;
  logic [WORD_W-1:0] word;

  always_comb begin
    word = (lr_in == fmt_left_level(fmt)) ? cap_left : cap_right;
  end

  always_comb begin
    seen_d = seen_q;
    lr_d   = lr_q;
    sh_d   = sh_q;
    sd_d   = sd_q;
    if (fall) begin
      lr_d = lr_in;
      if (!seen_q) begin
        seen_d = 1'b1;
      end else if (lr_in != lr_q) begin
        if (fmt == FMT_I2S) begin
          sd_d = 1'b0;
          sh_d = word;
        end else begin
          sd_d = word[WORD_W-1];
          sh_d = {word[WORD_W-2:0], 1'b0};
        end
      end else begin
        sd_d = sh_q[WORD_W-1];
        sh_d = {sh_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      lr_q   <= 1'b0;
      sh_q   <= '0;
      sd_q   <= 1'b0;
    end else begin
      seen_q <= seen_d;
      lr_q   <= lr_d;
      sh_q   <= sh_d;
      sd_q   <= sd_d;
    end
  end

  assign sdto = sd_q;

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import aport_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int MAX_HALF = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic              bck,
  input  logic              lrck,
  input  logic              sdti,
  input  logic [WORD_W-1:0] cap_left,
  input  logic [WORD_W-1:0] cap_right,
  output logic              sdto,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);

  localparam int CNT_W = $clog2(MAX_HALF + 1);

  logic [1:0] rst_pipe;
  logic       rst_q;
  fmt_e       mode_q;
  logic       bck_rise;
  logic       bck_fall;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // Format latch: loads only while the port is in reset.
  always_ff @(posedge clk) begin
    if (!rst_q) mode_q <= fmt_decode(mode_sel);
  end

  aport_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_q),
    .bck      (bck),
    .bck_rise (bck_rise),
    .bck_fall (bck_fall)
  );

  aport_rx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_q),
    .rise     (bck_rise),
    .lr_in    (lrck),
    .sd_in    (sdti),
    .fmt      (mode_q),
    .rx_left  (rx_left),
    .rx_right (rx_right),
    .rx_valid (rx_valid)
  );

  aport_tx #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_q),
    .fall      (bck_fall),
    .lr_in     (lrck),
    .fmt       (mode_q),
    .cap_left  (cap_left),
    .cap_right (cap_right),
    .sdto      (sdto)
  );

endmodule

// File: rtl/audio_serial_port_chk.sv
module audio_serial_port_chk
  import aport_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bck,
  input logic              sdto,
  input logic              rx_valid,
  input logic [WORD_W-1:0] rx_left,
  input logic [WORD_W-1:0] rx_right,
  input fmt_e              mode_q
);

  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_left_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_left != $past(rx_left)) |-> rx_valid);

  p_right_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_right != $past(rx_right)) |-> rx_valid);

  p_tx_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdto) |-> (!$past(bck) && $past(bck, 2)));

  p_rx_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(bck) && !$past(bck, 2)));

  p_sign_ext16_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode_q == FMT_L16) |->
      ((rx_left[WORD_W-1:15] == '0) || (rx_left[WORD_W-1:15] == '1)));

endmodule

bind audio_serial_port audio_serial_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .bck      (bck),
  .sdto     (sdto),
  .rx_valid (rx_valid),
  .rx_left  (rx_left),
  .rx_right (rx_right),
  .mode_q   (mode_q)
);

// File: tb/sim_audio_serial_port.sv
module sim_audio_serial_port;

  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   mode_sel;
  logic         bck;
  logic         lrck;
  logic         sdti;
  logic [W-1:0] cap_left;
  logic [W-1:0] cap_right;
  logic         sdto;
  logic [W-1:0] rx_left;
  logic [W-1:0] rx_right;
  logic         rx_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string rx_tag = "R3";
  int unsigned seed = 32'h1234_5678;
  logic [W-1:0] q_l[$];
  logic [W-1:0] q_r[$];
  logic [W-1:0] el, er;
  logic [W-1:0] cur_l, cur_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bck(bck), .lrck(lrck),
    .sdti(sdti), .cap_left(cap_left), .cap_right(cap_right), .sdto(sdto),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  function automatic logic [W-1:0] nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:8];
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference receive side: pairs queued by the stimulus, popped on each strobe.
  always @(negedge clk) begin
    if (rst_n && rx_valid === 1'b1) begin
      if (q_l.size() == 0) begin
        chk(1'b0, "R6 unexpected valid", W'(1), W'(0));
      end else begin
        el = q_l.pop_front();
        er = q_r.pop_front();
        chk(rx_left  === el, {rx_tag, " R6 left word"},  rx_left,  el);
        chk(rx_right === er, {rx_tag, " R6 right word"}, rx_right, er);
      end
    end
  end

  // One bit period: two clocks low then two high; returns at the last low-to-sample point.
  task automatic do_slot(input logic lv, input logic d);
    bck  = 1'b0;
    lrck = lv;
    sdti = d;
    @(negedge clk);
    @(negedge clk);
    bck = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input logic [2:0] code_rst, input logic [2:0] eff,
                     input logic [2:0] code_after, input int ratio, input int nfr);
    int half, lsbn;
    bit i2s;
    logic left_lv, lv, d, e;
    logic [W-1:0] p, wtx, ev, pl;
    string txtag;
    half = ratio / 2;
    lsbn = (eff == 3'b000) ? 16 : (eff == 3'b001) ? 20 : (eff == 3'b100) ? 24 : 0;
    i2s  = (eff == 3'b011);
    left_lv = i2s ? 1'b0 : 1'b1;
    rx_tag = i2s ? "R4" : (lsbn != 0) ? "R5" : "R3";
    if (code_rst != eff || code_after != code_rst) rx_tag = {rx_tag, " R2"};
    txtag = i2s ? "R8 R10 R11" : "R7 R10 R11";
    if (half < W) txtag = {txtag, " R9"};
    pl = '0;

    @(negedge clk);
    rst_n = 1'b0; bck = 1'b0; lrck = ~left_lv; sdti = 1'b0; mode_sel = code_rst;
    cur_l = nxt(); cur_r = nxt();
    cap_left = cur_l; cap_right = cur_r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdto === 1'b0,     "R1 sdto after reset",     W'(sdto), W'(0));
    chk(rx_valid === 1'b0, "R1 rx_valid after reset", W'(rx_valid), W'(0));
    chk(rx_left === '0,    "R1 rx_left after reset",  rx_left, W'(0));
    chk(rx_right === '0,   "R1 rx_right after reset", rx_right, W'(0));
    mode_sel = code_after;

    // Lead-in half-frame: no frame edge seen yet, output must stay low.
    for (int s = 0; s < half; s++) begin
      do_slot(~left_lv, nxt() & 1);
      chk(sdto === 1'b0, "R1 sdto before first edge", W'(sdto), W'(0));
      @(negedge clk);
    end

    for (int f = 0; f < nfr; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        lv  = (ch == 0) ? left_lv : ~left_lv;
        p   = nxt();
        wtx = (ch == 0) ? cur_l : cur_r;
        for (int s = 0; s < half; s++) begin
          if (lsbn != 0)
            d = (s >= half - lsbn) ? p[half - 1 - s] : nxt() & 1;
          else if (i2s)
            d = (s >= 1 && s <= W) ? p[W - s] : nxt() & 1;
          else
            d = (s < W) ? p[W - 1 - s] : nxt() & 1;
          if (i2s) e = (s >= 1 && s <= W) ? wtx[W - s] : 1'b0;
          else     e = (s < W) ? wtx[W - 1 - s] : 1'b0;
          do_slot(lv, d);
          chk(sdto === e, txtag, W'(sdto), W'(e));
          if (s == 5) begin
            if (ch == 0) begin cur_l = nxt(); cap_left = cur_l; end
            else         begin cur_r = nxt(); cap_right = cur_r; end
          end
          @(negedge clk);
        end
        ev = p;
        if (lsbn != 0)
          for (int i = lsbn; i < W; i++) ev[i] = p[lsbn - 1];
        if (ch == 0) pl = ev;
        else begin q_l.push_back(pl); q_r.push_back(ev); end
      end
    end

    for (int s = 0; s < 2; s++) begin
      do_slot(left_lv, 1'b0);
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(q_l.size() == 0, "R6 pending pair without valid", W'(q_l.size()), W'(0));
    q_l.delete();
    q_r.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bck = 1'b0; lrck = 1'b0; sdti = 1'b0; mode_sel = 3'b010;
    cap_left = '0; cap_right = '0; cur_l = '0; cur_r = '0;
    run(3'b000, 3'b000, 3'b000, 32, 3);
    run(3'b000, 3'b000, 3'b000, 64, 2);
    run(3'b001, 3'b001, 3'b001, 40, 3);
    run(3'b010, 3'b010, 3'b010, 48, 3);
    run(3'b010, 3'b010, 3'b000, 64, 3);
    run(3'b011, 3'b011, 3'b011, 64, 3);
    run(3'b011, 3'b011, 3'b010, 56, 2);
    run(3'b100, 3'b100, 3'b100, 48, 3);
    run(3'b100, 3'b100, 3'b100, 64, 2);
    run(3'b111, 3'b010, 3'b111, 48, 2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule